// File: doc/BRIEF.md
# Configurable Pin Port Controller

This block controls one port of configurable pins (eight by default) from a processor register bus. Each pin has its own output source. It can carry a bit written by software, a bit of an address byte captured on an address strobe, or the output of a logic flip-flop whose next value comes from user logic outside the block. Each pin can be set as an input or an output. Its driver can be push-pull, or it can emulate open drain, in which case the pin is only ever pulled low or released.

Software reaches the port through a small register window. It can read the pin levels, set the source selections, direction and drive style, and read back the driver enables actually in effect. It can also load the flip-flops directly, except for bits that a mask register protects. Those protected bits keep following their logic-driven next-state inputs. Read data is registered: the value appears on the cycle after the read strobe and stays there until the next read.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset on the second rising clock edge after the input goes high.

Top module: `cfg_port`

## Requirements
- R1: While reset is active, and after it is released, every register, every flip-flop and the address latch are zero, so no pin driver is enabled (pin_oe = 0). pin_oe falls to zero as soon as reset is asserted, without waiting for a clock edge.
- R2: A read of offset 0x00 returns pin_in as it stood at the clock edge that took the read. Read data appears on bus_rdata one cycle after the edge that took bus_rd, and it holds while bus_rd is low.
- R3: Pin i is driven only while bit i of the direction register (offset 0x06) is 1, whatever its source. Bit value 0 releases the pin.
- R4: A pin whose bits in the control register (0x02) and the route register (0x0A) are both 0 outputs bit i of the output data register (0x04).
- R5: A pin whose control bit is 1 and whose route bit is 0 outputs bit i of the latched address byte. The latch captures addr_in at a clock edge where ale is 1 and holds it otherwise.
- R6: A pin whose route bit is 1 outputs flip-flop i. This takes priority over both the address source and the output data source.
- R7: When drive-select bit i (offset 0x08) is 1, pin_out[i] is 0, and pin_oe[i] is 1 only when the pin is an output and its selected source bit is 0.
- R8: A read of offset 0x0C returns pin_oe.
- R9: At each clock edge, flip-flop i takes mc_next[i]. The exception is a bus write to offset 0x10 with mask bit i equal to 0: then the flip-flop takes write data bit i. Reads of 0x10 return the flip-flop outputs.
- R10: Mask bit i (offset 0x12) equal to 1 blocks software writes to flip-flop i, which then takes mc_next[i].
- R11: Writes to 0x00, to 0x0C and to unmapped offsets change nothing. Reads of unmapped offsets return 0.
- R12: Registers at 0x02, 0x04, 0x06, 0x08, 0x0A and 0x12 read back the last value written. Bit i of each register belongs to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | W | Write data |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read strobe, taken at the clock edge |
| bus_rdata | output | W | Registered read data |
| pin_in | input | W | Pin levels seen at the pads |
| pin_out | output | W | Value driven to the pads |
| pin_oe | output | W | Driver enable per pin |
| ale | input | 1 | Address latch strobe |
| addr_in | input | W | Address byte to latch |
| mc_next | input | W | Next-state inputs of the flip-flops |

## Verification
A wrong configuration bit shows up at pin_out or pin_oe on the cycle after the write that set it, because the pin path from the registers to the pads is purely combinational. Flip-flop faults and mask faults last only one cycle, since the flip-flops go back to mc_next at the next edge. They must therefore be observed on the pins directly after the write edge, with the pins routed to the flip-flops. A fault in read decoding stays hidden until a read, and then appears one cycle later and holds on bus_rdata until the next read.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  // Per-pin configuration handed to each pin slice
  typedef struct packed {
    logic sel_mc;    // route flip-flop output (highest priority)
    logic sel_addr;  // route latched address bit
    logic dir;       // 1 = output
    logic od;        // 1 = open-drain emulation
  } pin_cfg_t;

  // Decoded register selection
  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DIN,
    SEL_CTRL,
    SEL_DOUT,
    SEL_DIR,
    SEL_DRV,
    SEL_ROUTE,
    SEL_OE,
    SEL_MCELL,
    SEL_MASK
  } reg_sel_e;

endpackage

// File: rtl/cfg_port_rstsync.sv
module cfg_port_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
  import cfg_port_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_DIN   = 'h00,
  parameter logic [ADDR_W-1:0] OFS_CTRL  = 'h02,
  parameter logic [ADDR_W-1:0] OFS_DOUT  = 'h04,
  parameter logic [ADDR_W-1:0] OFS_DIR   = 'h06,
  parameter logic [ADDR_W-1:0] OFS_DRV   = 'h08,
  parameter logic [ADDR_W-1:0] OFS_ROUTE = 'h0A,
  parameter logic [ADDR_W-1:0] OFS_OE    = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_MCELL = 'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK  = 'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  input  logic [W-1:0]      oe_stat,
  input  logic [W-1:0]      mcell,
  output logic [W-1:0]      ctrl_q,
  output logic [W-1:0]      dout_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      drv_q,
  output logic [W-1:0]      route_q,
  output logic [W-1:0]      mask_q,
  output logic              mc_wr_hit
);
  reg_sel_e sel;

  // Offset decode
  always_comb begin
    if      (bus_addr == OFS_DIN)   sel = SEL_DIN;
    else if (bus_addr == OFS_CTRL)  sel = SEL_CTRL;
    else if (bus_addr == OFS_DOUT)  sel = SEL_DOUT;
    else if (bus_addr == OFS_DIR)   sel = SEL_DIR;
    else if (bus_addr == OFS_DRV)   sel = SEL_DRV;
    else if (bus_addr == OFS_ROUTE) sel = SEL_ROUTE;
    else if (bus_addr == OFS_OE)    sel = SEL_OE;
    else if (bus_addr == OFS_MCELL) sel = SEL_MCELL;
    else if (bus_addr == OFS_MASK)  sel = SEL_MASK;
    else                            sel = SEL_NONE;
  end

  // Clock enables for the writable registers
  logic ce_ctrl, ce_dout, ce_dir, ce_drv, ce_route, ce_mask;

  always_comb begin
    ce_ctrl   = bus_wr && (sel == SEL_CTRL);
    ce_dout   = bus_wr && (sel == SEL_DOUT);
    ce_dir    = bus_wr && (sel == SEL_DIR);
    ce_drv    = bus_wr && (sel == SEL_DRV);
    ce_route  = bus_wr && (sel == SEL_ROUTE);
    ce_mask   = bus_wr && (sel == SEL_MASK);
    mc_wr_hit = bus_wr && (sel == SEL_MCELL);
  end

  // Read data next state
  logic [W-1:0] rdata_d;

  always_comb begin
    rdata_d = bus_rdata;
    if (bus_rd) begin
      case (sel)
        SEL_DIN:   rdata_d = pin_in;
        SEL_CTRL:  rdata_d = ctrl_q;
        SEL_DOUT:  rdata_d = dout_q;
        SEL_DIR:   rdata_d = dir_q;
        SEL_DRV:   rdata_d = drv_q;
        SEL_ROUTE: rdata_d = route_q;
        SEL_OE:    rdata_d = oe_stat;
        SEL_MCELL: rdata_d = mcell;
        SEL_MASK:  rdata_d = mask_q;
        default:   rdata_d = '0;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      dout_q    <= '0;
      dir_q     <= '0;
      drv_q     <= '0;
      route_q   <= '0;
      mask_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (ce_ctrl)  ctrl_q  <= bus_wdata;
      if (ce_dout)  dout_q  <= bus_wdata;
      if (ce_dir)   dir_q   <= bus_wdata;
      if (ce_drv)   drv_q   <= bus_wdata;
      if (ce_route) route_q <= bus_wdata;
      if (ce_mask)  mask_q  <= bus_wdata;
      bus_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/cfg_port_mcell.sv
module cfg_port_mcell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mc_next,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  // Software load wins on unmasked bits; otherwise follow the logic.
  always_comb begin
    d = mc_next;
    if (wr_hit) d = (wdata & ~mask) | (mc_next & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cfg_port_alat.sv
module cfg_port_alat #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ale,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb d = ale ? addr_in : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cfg_port_pin.sv
module cfg_port_pin
  import cfg_port_pkg::*;
(
  input  pin_cfg_t cfg,
  input  logic     gpio_d,
  input  logic     addr_d,
  input  logic     mc_d,
  output logic     pout,
  output logic     poe
);
  logic src;

  always_comb begin
    if (cfg.sel_mc)        src = mc_d;
    else if (cfg.sel_addr) src = addr_d;
    else                   src = gpio_d;

    if (cfg.od) begin
      pout = 1'b0;
      poe  = cfg.dir & ~src;
    end else begin
      pout = src;
      poe  = cfg.dir;
    end
  end
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_port_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_DIN   = 'h00,
  parameter logic [ADDR_W-1:0] OFS_CTRL  = 'h02,
  parameter logic [ADDR_W-1:0] OFS_DOUT  = 'h04,
  parameter logic [ADDR_W-1:0] OFS_DIR   = 'h06,
  parameter logic [ADDR_W-1:0] OFS_DRV   = 'h08,
  parameter logic [ADDR_W-1:0] OFS_ROUTE = 'h0A,
  parameter logic [ADDR_W-1:0] OFS_OE    = 'h0C,
  parameter logic [ADDR_W-1:0] OFS_MCELL = 'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK  = 'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  input  logic              ale,
  input  logic [W-1:0]      addr_in,
  input  logic [W-1:0]      mc_next
);
  logic         rst_ok;
  logic [W-1:0] ctrl_q, dout_q, dir_q, drv_q, route_q, mask_q;
  logic [W-1:0] mcell_q, addr_lat;
  logic         mc_wr_hit;

  cfg_port_rstsync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  cfg_port_regs #(
    .W(W), .ADDR_W(ADDR_W),
    .OFS_DIN(OFS_DIN), .OFS_CTRL(OFS_CTRL), .OFS_DOUT(OFS_DOUT),
    .OFS_DIR(OFS_DIR), .OFS_DRV(OFS_DRV), .OFS_ROUTE(OFS_ROUTE),
    .OFS_OE(OFS_OE), .OFS_MCELL(OFS_MCELL), .OFS_MASK(OFS_MASK)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_ok),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .oe_stat   (pin_oe),
    .mcell     (mcell_q),
    .ctrl_q    (ctrl_q),
    .dout_q    (dout_q),
    .dir_q     (dir_q),
    .drv_q     (drv_q),
    .route_q   (route_q),
    .mask_q    (mask_q),
    .mc_wr_hit (mc_wr_hit)
  );

  cfg_port_mcell #(.W(W)) u_mcell (
    .clk     (clk),
    .rst_n   (rst_ok),
    .mc_next (mc_next),
    .wr_hit  (mc_wr_hit),
    .wdata   (bus_wdata),
    .mask    (mask_q),
    .q       (mcell_q)
  );

  cfg_port_alat #(.W(W)) u_alat (
    .clk     (clk),
    .rst_n   (rst_ok),
    .ale     (ale),
    .addr_in (addr_in),
    .q       (addr_lat)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_cfg_t cfg;
    always_comb begin
      cfg.sel_mc   = route_q[i];
      cfg.sel_addr = ctrl_q[i];
      cfg.dir      = dir_q[i];
      cfg.od       = drv_q[i];
    end

    cfg_port_pin u_pin (
      .cfg    (cfg),
      .gpio_d (dout_q[i]),
      .addr_d (addr_lat[i]),
      .mc_d   (mcell_q[i]),
      .pout   (pin_out[i]),
      .poe    (pin_oe[i])
    );
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         ale,
  input logic [W-1:0] addr_lat,
  input logic         bus_rd,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] drv_q,
  input logic [W-1:0] mcell_q,
  input logic [W-1:0] mc_next,
  input logic [W-1:0] mask_q
);
  p_idle_in_reset_r1: assert property (@(posedge clk)
    !rst_ok |-> pin_oe == '0);

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && !$past(bus_rd)) |-> $stable(bus_rdata));

  p_oe_needs_dir_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (pin_oe & ~dir_q) == '0);

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && !$past(ale)) |-> $stable(addr_lat));

  p_od_never_high_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (pin_out & pin_oe & drv_q) == '0);

  p_mask_follows_next_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) |-> ((mcell_q ^ $past(mc_next)) & $past(mask_q)) == '0);
endmodule

bind cfg_port cfg_port_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .ale       (ale),
  .addr_lat  (addr_lat),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .dir_q     (dir_q),
  .drv_q     (drv_q),
  .mcell_q   (mcell_q),
  .mc_next   (mc_next),
  .mask_q    (mask_q)
);

// File: tb/cfg_port_tb.sv
module cfg_port_tb;
  localparam int CLK_P = 10;
  localparam int W = 8;
  localparam int AW = 8;

  localparam logic [AW-1:0] A_DIN = 8'h00, A_CTRL = 8'h02, A_DOUT = 8'h04,
    A_DIR = 8'h06, A_DRV = 8'h08, A_ROUTE = 8'h0A, A_OE = 8'h0C,
    A_MC = 8'h10, A_MASK = 8'h12;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] bus_addr;
  logic [W-1:0]  bus_wdata, bus_rdata, pin_in, pin_out, pin_oe, addr_in, mc_next;
  logic bus_wr, bus_rd, ale;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .ale(ale), .addr_in(addr_in), .mc_next(mc_next)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 oe during reset", pin_oe, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [W-1:0] v;
    check("R1 oe after reset", pin_oe, 8'h00);
    rd(A_CTRL, v);  check("R1 ctrl", v, 8'h00);
    rd(A_DOUT, v);  check("R1 dout", v, 8'h00);
    rd(A_DIR, v);   check("R1 dir", v, 8'h00);
    rd(A_DRV, v);   check("R1 drv", v, 8'h00);
    rd(A_ROUTE, v); check("R1 route", v, 8'h00);
    rd(A_MASK, v);  check("R1 mask", v, 8'h00);
    rd(A_MC, v);    check("R1 mcell", v, 8'h00);
  endtask

  task automatic t_readback();
    logic [W-1:0] v;
    wr(A_CTRL, 8'h3C); wr(A_DOUT, 8'hA5); wr(A_DIR, 8'h81);
    wr(A_DRV, 8'h42); wr(A_ROUTE, 8'h18); wr(A_MASK, 8'h99);
    rd(A_CTRL, v);  check("R12 ctrl", v, 8'h3C);
    rd(A_DOUT, v);  check("R12 dout", v, 8'hA5);
    rd(A_DIR, v);   check("R12 dir", v, 8'h81);
    rd(A_DRV, v);   check("R12 drv", v, 8'h42);
    rd(A_ROUTE, v); check("R12 route", v, 8'h18);
    rd(A_MASK, v);  check("R12 mask", v, 8'h99);
    wr(A_CTRL, 8'h00); wr(A_DOUT, 8'h00); wr(A_DIR, 8'h00);
    wr(A_DRV, 8'h00); wr(A_ROUTE, 8'h00); wr(A_MASK, 8'h00);
  endtask

  task automatic t_din();
    logic [W-1:0] v;
    pin_in = 8'h96;
    rd(A_DIN, v); check("R2 pin readback", v, 8'h96);
    pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    check("R2 rdata holds", bus_rdata, 8'h96);
    rd(A_DIN, v); check("R2 pin readback 2", v, 8'h3C);
  endtask

  task automatic t_gpio();
    logic [W-1:0] v;
    wr(A_DOUT, 8'hAA); wr(A_DIR, 8'h0F);
    check("R3 oe follows dir", pin_oe, 8'h0F);
    check("R4 driven data", pin_out & pin_oe, 8'h0A);
    rd(A_OE, v); check("R8 oe status", v, 8'h0F);
    wr(A_DIR, 8'h00);
    check("R3 released", pin_oe, 8'h00);
  endtask

  task automatic t_addr();
    @(negedge clk); ale = 1'b1; addr_in = 8'h5A;
    @(negedge clk); ale = 1'b0; addr_in = 8'hFF;
    wr(A_DIR, 8'hFF); wr(A_DOUT, 8'h03); wr(A_CTRL, 8'hF0);
    check("R5 mixed addr/gpio", pin_out, 8'h53);
    wr(A_CTRL, 8'hFF);
    check("R5 latched byte held", pin_out, 8'h5A);
  endtask

  task automatic t_route();
    mc_next = 8'hCC;
    wr(A_ROUTE, 8'h0F);
    check("R6 route priority", pin_out, 8'h5C);
    wr(A_ROUTE, 8'h00); wr(A_CTRL, 8'h00);
    mc_next = 8'h00;
  endtask

  task automatic t_open_drain();
    logic [W-1:0] v;
    wr(A_DOUT, 8'hA5); wr(A_DRV, 8'hFF);
    check("R7 od oe", pin_oe, 8'h5A);
    check("R7 od out", pin_out, 8'h00);
    rd(A_OE, v); check("R8 oe status od", v, 8'h5A);
    wr(A_DRV, 8'h00);
  endtask

  task automatic t_mcell();
    logic [W-1:0] v;
    wr(A_ROUTE, 8'hFF);
    mc_next = 8'h00;
    wr(A_MC, 8'h96);
    check("R9 write wins", pin_out, 8'h96);
    @(negedge clk);
    check("R9 back to next", pin_out, 8'h00);
    mc_next = 8'h3C;
    @(negedge clk);
    rd(A_MC, v); check("R9 mcell readback", v, 8'h3C);
    mc_next = 8'h00;
    wr(A_MASK, 8'h0F);
    wr(A_MC, 8'hFF);
    check("R10 masked write", pin_out, 8'hF0);
    mc_next = 8'h0A;
    wr(A_MC, 8'hF5);
    check("R10 masked follows next", pin_out, 8'hFA);
    mc_next = 8'h00;
    wr(A_MASK, 8'h00); wr(A_ROUTE, 8'h00);
  endtask

  task automatic t_ignored();
    logic [W-1:0] v;
    wr(A_DOUT, 8'h5A);
    wr(A_DIN, 8'hFF); wr(A_OE, 8'hFF); wr(8'h01, 8'hFF); wr(8'hFF, 8'hFF);
    check("R11 pins unchanged oe", pin_oe, 8'hFF);
    check("R11 pins unchanged out", pin_out, 8'h5A);
    rd(A_DOUT, v); check("R11 dout unchanged", v, 8'h5A);
    rd(A_CTRL, v); check("R11 ctrl unchanged", v, 8'h00);
    rd(A_DRV, v);  check("R11 drv unchanged", v, 8'h00);
    rd(A_MASK, v); check("R11 mask unchanged", v, 8'h00);
    rd(8'h01, v);  check("R11 unmapped 01", v, 8'h00);
    rd(8'hFF, v);  check("R11 unmapped FF", v, 8'h00);
  endtask

  task automatic t_mid_reset();
    logic [W-1:0] v;
    do_reset();
    check("R1 oe after mid reset", pin_oe, 8'h00);
    rd(A_DIR, v);  check("R1 dir cleared", v, 8'h00);
    rd(A_DOUT, v); check("R1 dout cleared", v, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    pin_in = '0; ale = 1'b0; addr_in = '0; mc_next = '0;
    do_reset();
    t_reset_state();
    t_readback();
    t_din();
    t_gpio();
    t_addr();
    t_route();
    t_open_drain();
    t_mcell();
    t_ignored();
    t_mid_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule